// File: doc/BRIEF.md
# Horizontal Polyphase Line Downscaler

This block takes one video line at a time as a stream of pixels and emits a line with a different, usually smaller, number of pixels. Each output pixel is a four-tap weighted sum of neighbouring input pixels. A fixed-point position accumulator decides which four input pixels sit in the tap window. Its fractional part selects one of 33 coefficient sets held in a small on-block table. When the input and output widths match, or the scaler is switched off, pixels and their line markers pass straight through.

Software programs the widths, the position step, the starting phase and a control word through a write-only register port. It fills the coefficient table by writing a start index once and then streaming entries into a data register, which advances the index by itself. At the start of a line the tap window is cleared and then primed with a programmable number of pixels. The first pixel is replicated to pad the left edge. Once the input runs out, the last pixel is replicated to pad the right edge.

Top module: `hdown_scaler`

## Requirements
- R1: With the enable bit (control bit 0) clear, or with equal programmed widths, out_valid/out_data/out_sol/out_eol follow in_valid/in_data/in_sol/in_eol and in_ready follows out_ready. After reset the block is in this bypass.
- R2: Register 0 holds input width minus one in bits [31:16] and output width minus one in bits [15:0]. A scaled line produces exactly the output-width count of pixels: out_sol is on the first and out_eol is on the last.
- R3: Register 1 holds the step (1.0 = 2^24) and register 3 holds the initial phase in bits [23:0]. For output j the position is phase + j*step. n is its integer part. The table index is the 24-bit fraction plus 2^18, shifted right by 19 (0..32).
- R4: Writing register 5 sets the table index from bits [5:0] and the load enable from bit 8. Each write to register 4 with load enabled stores one entry at the index and then increments the index. With load disabled, writes to register 4 store nothing.
- R5: A table entry packs four signed 8-bit taps, tap i in bits [8i+7:8i], and tap 0 weights the oldest window pixel. The output is the sum of tap times pixel, plus 32, shifted arithmetically right by 6, then clamped to 0..255.
- R6: Scaling starts on an input pixel with in_sol. The window is cleared and that first pixel is inserted (control [11:10] + 1) times. Output j uses padded pixels p[R+n-4 .. R+n-1], where R is control bits [23:20] and p of a negative index is 0.
- R7: Once all input pixels are used, the last input pixel is repeated into the window for as many further positions as the output needs.
- R8: With control bit 1 set, the output is window pixel 1 when the table index is below 16, otherwise window pixel 2.
- R9: With control bit 2 set, table entry 0 is used for every output, whatever the phase.
- R10: While scaling, input pixels that arrive before the one carrying in_sol are accepted and discarded. A line consumes exactly the input-width count of pixels, including those left over after the last output.
- R11: A scaled output that is held by out_ready low keeps out_valid high and out_data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | 8 | Input pixel |
| in_sol | input | 1 | Input start of line |
| in_eol | input | 1 | Input end of line (used in bypass) |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output pixel |
| out_sol | output | 1 | Output start of line |
| out_eol | output | 1 | Output end of line |

## Verification
The bench sweeps shrink, expand and pass-through lines, several repeat counts, prime counts and phases, and both edge paddings. It computes every output pixel arithmetically from the padded-line formula. An off-by-one in priming or left padding would shift every output by one pixel. A wrong index rounding would choose the neighbouring coefficient set near phase boundaries. Missing right padding would stall or read zeros at the end of a line. A scaler that does not drain surplus input would corrupt the following line. Alternating full-scale pixels with negative taps exercise the clamp. A load with the enable bit clear, followed by a partial reload from index 16, shows whether the index port stores and advances correctly.

// File: rtl/hdown_scaler.sv
module hdown_scaler #(
  parameter int PIX_W      = 8,
  parameter int TAP_W      = 8,
  parameter int COEF_SHIFT = 6,
  parameter int FRAC_W     = 24,
  parameter int IDX_BITS   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sol,
  input  logic             in_eol,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sol,
  output logic             out_eol
);

  localparam int NTAPS    = 4;
  localparam int CW       = NTAPS * TAP_W;
  localparam int PHASES   = (1 << IDX_BITS) + 1;
  localparam int INT_W    = 24;
  localparam int ACC_W    = FRAC_W + INT_W;
  localparam int SUM_W    = PIX_W + TAP_W + 4;
  localparam int HALF_LSB = FRAC_W - IDX_BITS - 1;
  localparam logic [FRAC_W:0]   RND_ADD  = (FRAC_W+1)'(1) << HALF_LSB;
  localparam logic [IDX_BITS:0] HALF_IDX = (IDX_BITS+1)'(1 << (IDX_BITS-1));
  localparam logic [IDX_BITS:0] LAST_IDX = (IDX_BITS+1)'(PHASES - 1);
  localparam logic signed [SUM_W-1:0] PMAX = SUM_W'((1 << PIX_W) - 1);
  localparam logic signed [SUM_W-1:0] RBIAS = SUM_W'(1 << (COEF_SHIFT - 1));

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} st_e;

  logic [31:0]       width_q, step_q;
  logic [FRAC_W-1:0] phase_q;
  logic              en_q, nn_q, ph0_q, cload_q;
  logic [1:0]        rpt_q;
  logic [3:0]        rcv_q;
  logic [IDX_BITS:0] cidx_q;
  logic [CW-1:0]     cmem [PHASES];

  st_e               st_q;
  logic [INT_W-1:0]  s_q;
  logic [ACC_W-1:0]  acc_q;
  logic [16:0]       icnt_q, ocnt_q;
  logic [1:0]        rep_q;
  logic [PIX_W-1:0]  win_q [NTAPS];

  logic [16:0] w_in, w_out;
  logic        bypass, pass, last, need_shift, src_in, src_tail, shift_go, out_fire;
  logic [INT_W:0]      target;
  logic [FRAC_W:0]     frac_rnd;
  logic [IDX_BITS:0]   pidx;
  logic [CW-1:0]       coef_w;
  logic [PIX_W-1:0]    shift_pix, filt_pix, near_pix;
  logic signed [SUM_W-1:0] prod [NTAPS];
  logic signed [SUM_W-1:0] sum, scaled;

  assign w_in   = {1'b0, width_q[31:16]} + 17'd1;
  assign w_out  = {1'b0, width_q[15:0]} + 17'd1;
  assign bypass = !en_q || (width_q[31:16] == width_q[15:0]);
  assign pass   = bypass && (st_q == S_IDLE);
  assign last   = (ocnt_q == w_out - 17'd1);

  assign target     = {1'b0, acc_q[ACC_W-1:FRAC_W]} + {{(INT_W-3){1'b0}}, rcv_q};
  assign need_shift = {1'b0, s_q} < target;
  assign src_in     = (rep_q == 2'd0) && (icnt_q < w_in);
  assign src_tail   = (rep_q == 2'd0) && !src_in;
  assign shift_go   = need_shift && (src_tail || in_valid);
  assign shift_pix  = src_tail ? win_q[NTAPS-1] : in_data;
  assign out_fire   = (st_q == S_RUN) && !need_shift && out_ready;

  assign frac_rnd = {1'b0, acc_q[FRAC_W-1:0]} + RND_ADD;
  assign pidx     = ph0_q ? '0 : frac_rnd[FRAC_W -: IDX_BITS+1];
  assign coef_w   = cmem[pidx];

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    logic signed [SUM_W-1:0] pv, cv;
    assign pv = $signed({{(SUM_W-PIX_W){1'b0}}, win_q[g]});
    assign cv = $signed({{(SUM_W-TAP_W){coef_w[g*TAP_W+TAP_W-1]}}, coef_w[g*TAP_W +: TAP_W]});
    assign prod[g] = pv * cv;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NTAPS; i++) sum = sum + prod[i];
  end

  assign scaled = (sum + RBIAS) >>> COEF_SHIFT;

  always_comb begin
    if (scaled < 0)          filt_pix = '0;
    else if (scaled > PMAX)  filt_pix = PMAX[PIX_W-1:0];
    else                     filt_pix = scaled[PIX_W-1:0];
  end

  assign near_pix = (pidx < HALF_IDX) ? win_q[1] : win_q[2];

  always_comb begin
    if (pass) begin
      in_ready  = out_ready;
      out_valid = in_valid;
      out_data  = in_data;
      out_sol   = in_sol;
      out_eol   = in_eol;
    end else begin
      case (st_q)
        S_IDLE:  in_ready = !in_sol;
        S_RUN:   in_ready = need_shift && src_in;
        default: in_ready = 1'b1;
      endcase
      out_valid = (st_q == S_RUN) && !need_shift;
      out_data  = nn_q ? near_pix : filt_pix;
      out_sol   = (ocnt_q == 17'd0);
      out_eol   = last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
      step_q  <= 32'h0100_0000;
      phase_q <= '0;
      en_q    <= 1'b0;
      nn_q    <= 1'b0;
      ph0_q   <= 1'b0;
      rpt_q   <= 2'd1;
      rcv_q   <= 4'd4;
      cidx_q  <= '0;
      cload_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: width_q <= cfg_wdata;
        3'd1: step_q  <= cfg_wdata;
        3'd2: begin
          en_q  <= cfg_wdata[0];
          nn_q  <= cfg_wdata[1];
          ph0_q <= cfg_wdata[2];
          rpt_q <= cfg_wdata[11:10];
          rcv_q <= cfg_wdata[23:20];
        end
        3'd3: phase_q <= cfg_wdata[FRAC_W-1:0];
        3'd4: if (cload_q && cidx_q <= LAST_IDX)
                cidx_q <= (cidx_q == LAST_IDX) ? '0 : cidx_q + 1'b1;
        3'd5: begin
          cidx_q  <= cfg_wdata[IDX_BITS:0];
          cload_q <= cfg_wdata[8];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we && cfg_addr == 3'd4 && cload_q && cidx_q <= LAST_IDX)
      cmem[cidx_q] <= cfg_wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      s_q    <= '0;
      acc_q  <= '0;
      icnt_q <= '0;
      ocnt_q <= '0;
      rep_q  <= '0;
      for (int i = 0; i < NTAPS; i++) win_q[i] <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (in_valid && in_sol && !bypass) begin
          st_q   <= S_RUN;
          s_q    <= '0;
          acc_q  <= {{INT_W{1'b0}}, phase_q};
          icnt_q <= '0;
          ocnt_q <= '0;
          rep_q  <= rpt_q;
          for (int i = 0; i < NTAPS; i++) win_q[i] <= '0;
        end
        S_RUN: begin
          if (shift_go) begin
            for (int i = 0; i < NTAPS-1; i++) win_q[i] <= win_q[i+1];
            win_q[NTAPS-1] <= shift_pix;
            s_q <= s_q + 1'b1;
            if (rep_q != 2'd0) rep_q <= rep_q - 2'd1;
            else if (src_in)   icnt_q <= icnt_q + 17'd1;
          end else if (out_fire) begin
            ocnt_q <= ocnt_q + 17'd1;
            acc_q  <= acc_q + {{(ACC_W-32){1'b0}}, step_q};
            if (last) st_q <= (icnt_q == w_in) ? S_IDLE : S_DRAIN;
          end
        end
        default: if (in_valid) begin
          icnt_q <= icnt_q + 17'd1;
          if (icnt_q + 17'd1 == w_in) st_q <= S_IDLE;
        end
      endcase
    end
  end

  a_r11_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && out_valid && !out_ready && !cfg_we) |=> (out_valid && $stable(out_data)));

  a_r10_no_overread: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |-> (icnt_q <= w_in));

  a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN) |-> ({1'b0, s_q} <= target));

  a_r2_eol_ends_line: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_eol) |=> (st_q != S_RUN));

  a_r4_index_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd4 && cload_q && cidx_q <= LAST_IDX) |=> (cidx_q != $past(cidx_q)));

  a_r6_repeat_no_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && rep_q != 2'd0) |-> !in_ready);

endmodule

// File: tb/sim_hdown_scaler.sv
module sim_hdown_scaler;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_sol, out_eol;
  logic [7:0] out_data;

  int n_checks = 0, n_fail = 0;
  int xin [64];
  int ctab [33][4];
  int gdat [64];
  bit gsol [64], geol [64];
  int gcnt;
  int c_win, c_wout, c_rpt, c_rcv, c_nn, c_ph0;
  longint c_phase, c_step;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdown_scaler u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sol(in_sol), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sol(out_sol), .out_eol(out_eol)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int base_coef(int k, int i, bit mirror);
    int a = k >> 3;
    int t1 = 64 - 2*k + a;
    int t2 = 2*k + a;
    case (i)
      1: return mirror ? t2 : t1;
      2: return mirror ? t1 : t2;
      default: return -a;
    endcase
  endfunction

  function automatic int pack_coef(int k);
    int w = 0;
    for (int i = 0; i < 4; i++) w |= (ctab[k][i] & 255) << (8*i);
    return w;
  endfunction

  function automatic int padded(int k);
    int m;
    if (k < 0) return 0;
    if (k < c_rpt) return xin[0];
    m = k - c_rpt;
    if (m >= c_win) m = c_win - 1;
    return xin[m];
  endfunction

  function automatic int model(int j);
    longint pos = c_phase + longint'(j) * c_step;
    int n = int'(pos >> 24);
    int f = int'(pos & 64'hFF_FFFF);
    int idx = (f + (1 << 18)) >> 19;
    int base, sum;
    if (c_ph0 != 0) idx = 0;
    base = c_rcv + n - 4;
    if (c_nn != 0) return (idx < 16) ? padded(base + 1) : padded(base + 2);
    sum = 0;
    for (int i = 0; i < 4; i++) sum += ctab[idx][i] * padded(base + i);
    sum = (sum + 32) >>> 6;
    if (sum < 0) sum = 0;
    if (sum > 255) sum = 255;
    return sum;
  endfunction

  task automatic drive_line(input int pre, input int gap);
    for (int i = 0; i < pre + c_win; i++) begin
      @(negedge clk);
      if (gap != 0 && (i % 3) == 2) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = (i < pre) ? 8'hAA : 8'(xin[i-pre]);
      in_sol   = (i == pre);
      in_eol   = (i == pre + c_win - 1);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
  endtask

  task automatic collect(input int bp);
    int k = 0;
    gcnt = 0;
    while (k < 3000) begin
      @(negedge clk);
      out_ready = (bp != 0) ? ((k % 3) != 1) : 1'b1;
      k++;
      #1;
      if (out_valid && out_ready) begin
        gdat[gcnt] = out_data; gsol[gcnt] = out_sol; geol[gcnt] = out_eol;
        gcnt++;
        if (out_eol || gcnt == 64) break;
      end
    end
  endtask

  task automatic run_line(input int win, input int wout, input int en, input int nn,
                          input int ph0, input int rpt, input int rcv, input int phase,
                          input int pat, input int bp, input int gap, input string req);
    bit byp = (en == 0) || (win == wout);
    int expn = byp ? win : wout;
    int e;
    c_win = win; c_wout = wout; c_rpt = rpt; c_rcv = rcv; c_nn = nn; c_ph0 = ph0;
    c_phase = phase;
    c_step = ((longint'(win) << 20) / wout) << 4;
    for (int i = 0; i < win; i++)
      xin[i] = (pat == 1) ? ((i & 1) ? 255 : 0) : (pat == 2) ? ((i * 29) & 255) : ((i*37 + win*13 + 5) & 255);
    cfg_write(0, ((win - 1) << 16) | (wout - 1));
    cfg_write(1, int'(c_step));
    cfg_write(2, en | (nn << 1) | (ph0 << 2) | (rpt << 10) | (rcv << 20));
    cfg_write(3, phase);
    fork
      drive_line(byp ? 0 : 2, gap);
      collect(bp);
    join
    check(gcnt == expn, {req, " R2 output count"}, gcnt, expn);
    for (int j = 0; j < gcnt && j < expn; j++) begin
      e = byp ? xin[j] : model(j);
      check(gdat[j] == e, req, gdat[j], e);
    end
    if (gcnt > 0) begin
      check(gsol[0] == 1'b1, {req, " R2 sol on first"}, gsol[0], 1);
      check(geol[gcnt-1] == 1'b1, {req, " R2 eol on last"}, geol[gcnt-1], 1);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R1 reset bypass in_ready follows out_ready", in_ready, 1);
    out_ready = 1'b0;
    #1;
    check(in_ready == 1'b0, "R1 reset bypass in_ready low", in_ready, 0);

    for (int k = 0; k < 33; k++)
      for (int i = 0; i < 4; i++) ctab[k][i] = base_coef(k, i, 1'b0);
    cfg_write(5, 32'h100);
    for (int k = 0; k < 33; k++) cfg_write(4, pack_coef(k));

    run_line(8, 5, 0, 0, 0, 1, 4, 0, 0, 0, 0, "R1 disabled bypass");
    run_line(6, 6, 1, 0, 0, 1, 4, 0, 0, 1, 0, "R1 equal width bypass");
    run_line(8, 5, 1, 0, 0, 1, 4, 0, 0, 0, 0, "R3 R5 R10 shrink 8to5");
    run_line(8, 3, 1, 0, 0, 1, 4, 0, 2, 1, 1, "R11 R10 shrink 8to3 backpressure");
    run_line(9, 4, 1, 0, 0, 0, 3, 32'h40_0000, 0, 0, 0, "R6 R3 rpt0 rcv3 phase");
    run_line(6, 4, 1, 0, 0, 3, 5, 32'hC8_0000, 2, 0, 1, "R6 rpt3 rcv5");
    run_line(4, 7, 1, 0, 0, 1, 4, 0, 0, 1, 0, "R3 expand 4to7");
    run_line(4, 3, 1, 0, 0, 0, 6, 32'hF0_0000, 0, 0, 0, "R7 tail repeat");
    run_line(8, 5, 1, 1, 0, 1, 4, 32'h10_0000, 0, 0, 0, "R8 nearest");
    run_line(8, 5, 1, 0, 1, 1, 4, 32'h80_0000, 0, 0, 0, "R9 force phase0");
    run_line(10, 7, 1, 0, 0, 2, 4, 32'h30_0000, 1, 0, 0, "R5 clamp extremes");

    cfg_write(5, 32'h000);
    cfg_write(4, 32'h7f7f7f7f);
    run_line(8, 5, 1, 0, 1, 1, 4, 0, 0, 0, 0, "R4 load disabled no store");

    cfg_write(5, 32'h100 | 16);
    for (int k = 16; k < 33; k++) begin
      for (int i = 0; i < 4; i++) ctab[k][i] = base_coef(k, i, 1'b1);
      cfg_write(4, pack_coef(k));
    end
    run_line(8, 5, 1, 0, 0, 1, 4, 0, 0, 0, 0, "R4 partial reload from 16");
    run_line(8, 6, 1, 0, 0, 1, 4, 32'h08_0000, 2, 1, 1, "R4 R11 reload shrink 8to6");

    finish_run();
  end
endmodule